// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block resolves the conditional branches of an 8-bit processor that uses a 16-bit program counter. A request carries the branch opcode byte, the four condition flags (negative, overflow, zero, carry), an 8-bit signed displacement and the address of the instruction that follows the branch. One clock edge later the block returns a registered result: whether the branch is taken, the address execution continues from, and how many cycles the branch instruction costs in total.

The condition comes straight from the opcode bits. The two top bits pick one of the four flags and the next bit gives the flag value that takes the branch. The cycle cost starts at a base of two. A taken branch adds one cycle. A taken branch whose target lands in a different 256-byte page from the next-instruction address adds one more. An opcode that is not one of the eight branch codes is flagged as illegal and never counts as taken.

Top module: `rel_branch_unit`

## Requirements
- R1: A request sampled with `req_valid` high at a rising clock edge raises `rsp_valid` for the cycle that follows that edge. A cycle without a request leaves `rsp_valid` low.
- R2: An opcode is a legal branch only when its bits 4:0 equal binary 10000. Its bits 7:6 choose the flag (00 negative, 01 overflow, 10 carry, 11 zero). Its bit 5 is the flag value that takes the branch.
- R3: A legal branch is taken exactly when the chosen flag equals opcode bit 5. Flags that are not chosen have no effect on the result.
- R4: A branch that is not taken reports a cycle count of 2.
- R5: A taken branch reports a target equal to the next-instruction address plus the sign-extended displacement, modulo 2^16.
- R6: A branch that is not taken reports a target equal to the next-instruction address.
- R7: A taken branch whose target bits 15:8 equal the next-instruction address bits 15:8 reports 3 cycles.
- R8: A taken branch whose target bits 15:8 differ from the next-instruction address bits 15:8 reports 4 cycles. This includes wrap-around past address FFFF or below 0000.
- R9: A non-branch opcode sets `rsp_illegal`, clears `rsp_taken`, reports the next-instruction address as target and reports 2 cycles, whatever the flags hold.
- R10: While reset is asserted, and up to the first request after it, every output is zero.
- R11: Between requests, `rsp_taken`, `rsp_target`, `rsp_cycles` and `rsp_illegal` keep the values of the last result, even while the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 8 | Opcode byte of the instruction |
| req_flag_n | input | 1 | Negative flag |
| req_flag_v | input | 1 | Overflow flag |
| req_flag_z | input | 1 | Zero flag |
| req_flag_c | input | 1 | Carry flag |
| req_disp | input | 8 | Signed displacement |
| req_next_pc | input | 16 | Address of the following instruction |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_taken | output | 1 | Branch is taken |
| rsp_target | output | 16 | Address to continue from |
| rsp_cycles | output | 3 | Total cycle cost of the instruction |
| rsp_illegal | output | 1 | Opcode is not a conditional branch |

## Verification
The two functions that can apply to the same instruction are the taken penalty and the page-crossing penalty. Both add to the same cycle count, so the count must reach 4 only when both apply. The stimulus table sets up taken branches with forward and backward displacements that cross a page, including a wrap past address FFFF. It also has a taken branch at the most negative displacement that stays inside the page, and not-taken branches whose displacement would have crossed a page. Each result is compared with a cycle count and target worked out by hand.

// File: rtl/brch_pkg.sv
package brch_pkg;

   typedef enum logic [1:0] {
      FLG_SIGN  = 2'b00,
      FLG_OVF   = 2'b01,
      FLG_CARRY = 2'b10,
      FLG_ZERO  = 2'b11
   } flag_sel_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } flags_t;

   localparam logic [4:0] BRANCH_SIG = 5'b10000;

endpackage

// File: rtl/brch_cond_decode.sv
module brch_cond_decode
   import brch_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] opcode,
   input  flags_t          flags,
   output logic            legal,
   output logic            cond_met
);
   localparam int SEL_HI  = OP_W - 1;
   localparam int SEL_LO  = OP_W - 2;
   localparam int POL_BIT = OP_W - 3;
   localparam int SIG_W   = OP_W - 3;

   generate
      if (OP_W != 8) begin : g_bad_width
         $error("brch_cond_decode: OP_W must be 8");
      end
   endgenerate

   flag_sel_e sel;
   logic      picked;

   always_comb begin
      sel   = flag_sel_e'(opcode[SEL_HI:SEL_LO]);
      legal = (opcode[SIG_W-1:0] == BRANCH_SIG);
      unique case (sel)
         FLG_SIGN:  picked = flags.n;
         FLG_OVF:   picked = flags.v;
         FLG_CARRY: picked = flags.c;
         FLG_ZERO:  picked = flags.z;
         default:   picked = 1'b0;
      endcase
      cond_met = legal && (picked == opcode[POL_BIT]);
   end

endmodule

// File: rtl/brch_target_calc.sv
module brch_target_calc #(
   parameter int PC_W           = 16,
   parameter int DISP_W         = 8,
   parameter int PAGE_BITS      = 8,
   parameter bit CROSS_BY_CARRY = 1'b1
) (
   input  logic [PC_W-1:0]   next_pc,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   target,
   output logic              page_cross
);
   localparam int EXT_W = PC_W - DISP_W;

   generate
      if (PC_W <= PAGE_BITS) begin : g_bad_page
         $error("brch_target_calc: PC_W must exceed PAGE_BITS");
      end
      if (DISP_W > PC_W) begin : g_bad_disp
         $error("brch_target_calc: DISP_W must not exceed PC_W");
      end
   endgenerate

   logic [PC_W-1:0] disp_ext;

   always_comb begin
      disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      target   = next_pc + disp_ext;
   end

   generate
      if (CROSS_BY_CARRY) begin : g_carry
         if (DISP_W > PAGE_BITS) begin : g_bad_carry
            $error("brch_target_calc: carry variant needs DISP_W <= PAGE_BITS");
         end
         logic [PAGE_BITS:0] low_sum;
         always_comb begin
            low_sum    = {1'b0, next_pc[PAGE_BITS-1:0]} + {1'b0, disp_ext[PAGE_BITS-1:0]};
            page_cross = low_sum[PAGE_BITS] ^ disp[DISP_W-1];
         end
      end else begin : g_compare
         always_comb begin
            page_cross = (target[PC_W-1:PAGE_BITS] != next_pc[PC_W-1:PAGE_BITS]);
         end
      end
   endgenerate

endmodule

// File: rtl/brch_cycle_count.sv
module brch_cycle_count #(
   parameter int CNT_W      = 3,
   parameter int BASE_CYC   = 2,
   parameter int TAKEN_CYC  = 1,
   parameter int CROSS_CYC  = 1
) (
   input  logic             taken,
   input  logic             page_cross,
   output logic [CNT_W-1:0] cycles
);
   localparam int MAX_CYC = BASE_CYC + TAKEN_CYC + CROSS_CYC;
   localparam logic [CNT_W-1:0] BASE_C  = CNT_W'(BASE_CYC);
   localparam logic [CNT_W-1:0] TAKEN_C = CNT_W'(TAKEN_CYC);
   localparam logic [CNT_W-1:0] CROSS_C = CNT_W'(CROSS_CYC);

   generate
      if (MAX_CYC >= (1 << CNT_W)) begin : g_bad_cnt
         $error("brch_cycle_count: CNT_W too narrow for the largest count");
      end
   endgenerate

   always_comb begin
      cycles = BASE_C;
      if (taken) begin
         cycles = cycles + TAKEN_C;
         if (page_cross) begin
            cycles = cycles + CROSS_C;
         end
      end
   end

endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
   import brch_pkg::*;
#(
   parameter int OP_W           = 8,
   parameter int PC_W           = 16,
   parameter int DISP_W         = 8,
   parameter int PAGE_BITS      = 8,
   parameter int CNT_W          = 3,
   parameter int BASE_CYC       = 2,
   parameter int TAKEN_CYC      = 1,
   parameter int CROSS_CYC      = 1,
   parameter bit CROSS_BY_CARRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OP_W-1:0]   req_opcode,
   input  logic              req_flag_n,
   input  logic              req_flag_v,
   input  logic              req_flag_z,
   input  logic              req_flag_c,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [PC_W-1:0]   req_next_pc,
   output logic              rsp_valid,
   output logic              rsp_taken,
   output logic [PC_W-1:0]   rsp_target,
   output logic [CNT_W-1:0]  rsp_cycles,
   output logic              rsp_illegal
);
   localparam int EXT_W = PC_W - DISP_W;
   localparam logic [CNT_W-1:0] NT_CYC   = CNT_W'(BASE_CYC);
   localparam logic [CNT_W-1:0] NEAR_CYC = CNT_W'(BASE_CYC + TAKEN_CYC);
   localparam logic [CNT_W-1:0] FAR_CYC  = CNT_W'(BASE_CYC + TAKEN_CYC + CROSS_CYC);

   flags_t           flags;
   logic             legal;
   logic             cond_met;
   logic [PC_W-1:0]  calc_target;
   logic             page_cross;
   logic [CNT_W-1:0] calc_cycles;
   logic [PC_W-1:0]  final_target;

   assign flags = '{n: req_flag_n, v: req_flag_v, z: req_flag_z, c: req_flag_c};

   brch_cond_decode #(
      .OP_W (OP_W)
   ) u_dec (
      .opcode   (req_opcode),
      .flags    (flags),
      .legal    (legal),
      .cond_met (cond_met)
   );

   brch_target_calc #(
      .PC_W           (PC_W),
      .DISP_W         (DISP_W),
      .PAGE_BITS      (PAGE_BITS),
      .CROSS_BY_CARRY (CROSS_BY_CARRY)
   ) u_tgt (
      .next_pc    (req_next_pc),
      .disp       (req_disp),
      .target     (calc_target),
      .page_cross (page_cross)
   );

   brch_cycle_count #(
      .CNT_W     (CNT_W),
      .BASE_CYC  (BASE_CYC),
      .TAKEN_CYC (TAKEN_CYC),
      .CROSS_CYC (CROSS_CYC)
   ) u_cnt (
      .taken      (cond_met),
      .page_cross (page_cross),
      .cycles     (calc_cycles)
   );

   always_comb begin
      final_target = cond_met ? calc_target : req_next_pc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_taken   <= 1'b0;
         rsp_target  <= '0;
         rsp_cycles  <= '0;
         rsp_illegal <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_taken   <= cond_met;
            rsp_target  <= final_target;
            rsp_cycles  <= calc_cycles;
            rsp_illegal <= !legal;
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1
   AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1
   AST_NT_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_taken) |-> (rsp_cycles == NT_CYC)); // R4
   AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cond_met) |=> (rsp_target ==
         $past(req_next_pc) + {{EXT_W{$past(req_disp[DISP_W-1])}}, $past(req_disp)})); // R5
   AST_NT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cond_met) |=> (rsp_target == $past(req_next_pc))); // R6
   AST_NEAR_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cond_met && (calc_target[PC_W-1:PAGE_BITS] == req_next_pc[PC_W-1:PAGE_BITS]))
      |=> (rsp_cycles == NEAR_CYC)); // R7
   AST_FAR_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cond_met && (calc_target[PC_W-1:PAGE_BITS] != req_next_pc[PC_W-1:PAGE_BITS]))
      |=> (rsp_cycles == FAR_CYC)); // R8
   AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_illegal) |-> !rsp_taken); // R9
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_taken) && $stable(rsp_target) &&
                      $stable(rsp_cycles) && $stable(rsp_illegal))); // R11

endmodule

// File: tb/sim_rel_branch_unit.sv
module sim_rel_branch_unit;
   localparam int CLK_P = 10;
   localparam int NVEC  = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_opcode = '0;
   logic        req_flag_n = 1'b0;
   logic        req_flag_v = 1'b0;
   logic        req_flag_z = 1'b0;
   logic        req_flag_c = 1'b0;
   logic [7:0]  req_disp = '0;
   logic [15:0] req_next_pc = '0;
   logic        rsp_valid;
   logic        rsp_taken;
   logic [15:0] rsp_target;
   logic [2:0]  rsp_cycles;
   logic        rsp_illegal;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   rel_branch_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_opcode  (req_opcode),
      .req_flag_n  (req_flag_n),
      .req_flag_v  (req_flag_v),
      .req_flag_z  (req_flag_z),
      .req_flag_c  (req_flag_c),
      .req_disp    (req_disp),
      .req_next_pc (req_next_pc),
      .rsp_valid   (rsp_valid),
      .rsp_taken   (rsp_taken),
      .rsp_target  (rsp_target),
      .rsp_cycles  (rsp_cycles),
      .rsp_illegal (rsp_illegal)
   );

   // {opcode, N V Z C, disp, next_pc, exp_taken, exp_target, exp_cycles, exp_illegal}
   localparam logic [56:0] VEC [NVEC] = '{
      {8'h10, 4'b0000, 8'h05, 16'h1000, 1'b1, 16'h1005, 3'd3, 1'b0},
      {8'h30, 4'b0000, 8'h05, 16'h1000, 1'b0, 16'h1000, 3'd2, 1'b0},
      {8'h30, 4'b1000, 8'hFE, 16'h1001, 1'b1, 16'h0FFF, 3'd4, 1'b0},
      {8'h50, 4'b0100, 8'h7F, 16'h2080, 1'b0, 16'h2080, 3'd2, 1'b0},
      {8'h70, 4'b0100, 8'h7F, 16'h20F0, 1'b1, 16'h216F, 3'd4, 1'b0},
      {8'h90, 4'b0001, 8'h80, 16'h3000, 1'b0, 16'h3000, 3'd2, 1'b0},
      {8'hB0, 4'b0001, 8'h80, 16'h3080, 1'b1, 16'h3000, 3'd3, 1'b0},
      {8'hD0, 4'b0010, 8'h40, 16'h40F0, 1'b0, 16'h40F0, 3'd2, 1'b0},
      {8'hF0, 4'b0010, 8'h10, 16'h40F8, 1'b1, 16'h4108, 3'd4, 1'b0},
      {8'hD0, 4'b1101, 8'h01, 16'hFFFF, 1'b1, 16'h0000, 3'd4, 1'b0},
      {8'h00, 4'b1111, 8'h05, 16'h5000, 1'b0, 16'h5000, 3'd2, 1'b1},
      {8'h18, 4'b0000, 8'hF0, 16'h6000, 1'b0, 16'h6000, 3'd2, 1'b1},
      {8'h90, 4'b1110, 8'h00, 16'h7000, 1'b1, 16'h7000, 3'd3, 1'b0},
      {8'hF1, 4'b0010, 8'h20, 16'h8000, 1'b0, 16'h8000, 3'd2, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] op, input logic [3:0] f,
                        input logic [7:0] d, input logic [15:0] pc);
      req_valid   = 1'b1;
      req_opcode  = op;
      {req_flag_n, req_flag_v, req_flag_z, req_flag_c} = f;
      req_disp    = d;
      req_next_pc = pc;
   endtask

   task automatic check_rsp(input string req, input logic tk, input logic [15:0] tg,
                            input logic [2:0] cy, input logic il);
      chk(rsp_valid == 1'b1, "R1", "valid", 32'(rsp_valid), 32'd1);
      chk(rsp_taken == tk, req, "taken", 32'(rsp_taken), 32'(tk));
      chk(rsp_target == tg, req, "target", 32'(rsp_target), 32'(tg));
      chk(rsp_cycles == cy, req, "cycles", 32'(rsp_cycles), 32'(cy));
      chk(rsp_illegal == il, req, "illegal", 32'(rsp_illegal), 32'(il));
   endtask

   function automatic string req_of(input logic tk, input logic [15:0] tg,
                                    input logic [2:0] cy, input logic il);
      if (il) return "R9";
      if (!tk) return "R4_R6";
      if (cy == 3'd4) return "R8";
      return "R7";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (2) @(negedge clk);
      chk(rsp_valid == 1'b0 && rsp_taken == 1'b0 && rsp_illegal == 1'b0,
          "R10", "flags in reset", {29'd0, rsp_valid, rsp_taken, rsp_illegal}, 32'd0);
      chk(rsp_target == 16'h0 && rsp_cycles == 3'd0, "R10", "target/cycles in reset",
          {13'd0, rsp_cycles, rsp_target}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0 && rsp_target == 16'h0, "R10", "after release",
          {15'd0, rsp_valid, rsp_target}, 32'd0);

      // R2 R3 R5 R7 R8 R9: table of vectors
      for (int i = 0; i < NVEC; i++) begin
         logic [56:0] v;
         v = VEC[i];
         drive(v[56:49], v[48:45], v[44:37], v[36:21]);
         @(negedge clk);
         check_rsp(req_of(v[20], v[19:4], v[3:1], v[0]), v[20], v[19:4], v[3:1], v[0]);
         req_valid = 1'b0;
      end

      // R1 R11: idle cycles with moving inputs keep the last result
      for (int k = 0; k < 3; k++) begin
         req_opcode  = 8'h10;
         req_next_pc = 16'h9000 + 16'(k);
         req_disp    = 8'h33;
         {req_flag_n, req_flag_v, req_flag_z, req_flag_c} = 4'b0000;
         @(negedge clk);
         chk(rsp_valid == 1'b0, "R1", "no request valid", 32'(rsp_valid), 32'd0);
         chk(rsp_taken == 1'b0 && rsp_illegal == 1'b1, "R11", "held taken/illegal",
             {30'd0, rsp_taken, rsp_illegal}, 32'd1);
         chk(rsp_target == 16'h8000 && rsp_cycles == 3'd2, "R11", "held target/cycles",
             {13'd0, rsp_cycles, rsp_target}, {13'd2, 16'h8000});
      end

      // R1 R3: back-to-back requests, unchosen flags set
      drive(8'h10, 4'b0111, 8'h02, 16'h0100);
      @(negedge clk);
      check_rsp("R3", 1'b1, 16'h0102, 3'd3, 1'b0);
      drive(8'hF0, 4'b1101, 8'h02, 16'h0200);
      @(negedge clk);
      check_rsp("R3", 1'b0, 16'h0200, 3'd2, 1'b0);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", "single pulse", 32'(rsp_valid), 32'd0);

      // R8: backward wrap below 0000 with displacement -1
      drive(8'h90, 4'b1110, 8'hFF, 16'h0000);
      @(negedge clk);
      check_rsp("R8", 1'b1, 16'hFFFF, 3'd4, 1'b0);
      req_valid = 1'b0;

      // R10: reset again clears a live result
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(rsp_target == 16'h0 && rsp_cycles == 3'd0 && rsp_taken == 1'b0, "R10",
          "reset clears", {13'd0, rsp_cycles, rsp_target}, 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule